// File: doc/BRIEF.md
# Rotating-destination UDP payload framer

The block turns a stream of 64-bit words, already grouped by channel, into UDP payloads for a pair of 10GbE-style transmit ports. A packet is formed from every 256 accepted input words. Each packet starts with one header word that carries a spectrum counter. The 256 data words follow, and the last of them is flagged as end-of-frame. Packets go to the two transmit lanes in turn: lane 0 takes the even packets and lane 1 the odd ones. While one lane finishes its frame, the other lane can already take the next packet.

A 16-entry table of destination IPv4 addresses is stepped through, one entry per packet, and wraps after the last entry. The selected address is held on the lane for the whole frame. The UDP destination port comes from a single configuration input and is shared by both lanes.

Input words are accepted on every cycle where `in_valid` is high. An upstream stall closes nothing: the open frame simply pauses.

Top module: `udp_group_framer`

## Requirements
- R1: After reset, both lanes show tx_valid and tx_end_of_frame low. The first packet uses lane 0 and table entry 0.
- R2: A lane's first valid beat of a packet is a header word: the `spec_count` value present on the cycle the packet's first word is accepted, zero-extended to 64 bits. It appears on the cycle after that acceptance.
- R3: An input word accepted at a clock edge appears on its lane's tx_data in the following cycle, one cycle later than a direct pass-through. Data words keep their input order.
- R4: Each packet is exactly 257 valid beats on its lane: one header and 256 data words (2056 bytes).
- R5: tx_end_of_frame is high on exactly one cycle per packet. That cycle is the one carrying the 256th data word, and tx_valid is high on it.
- R6: Packets alternate lanes. Packet n goes to lane n mod 2, where lane l occupies tx_data bits [64l+63:64l].
- R7: Packet n carries the address from table entry (n mod 16) on its lane's tx_dest_ip. Entry i occupies dest_table bits [32i+31:32i]. The address stays stable from the header beat through the end-of-frame beat.
- R8: After the packet that uses entry 15, the next packet uses entry 0 again.
- R9: If the input stalls partway through a packet, the lane's tx_valid goes low for the stalled cycles and tx_end_of_frame stays low. The frame then resumes with the next accepted word.
- R10: tx_dest_port always equals udp_port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 64 | Reordered channel-group word |
| in_valid | input | 1 | in_data is accepted this cycle |
| spec_count | input | 32 | Spectrum counter to place in the header |
| dest_table | input | 512 | 16 destination IPv4 addresses, entry i at bits [32i+31:32i] |
| udp_port | input | 16 | Configured UDP destination port |
| tx_data | output | 128 | Payload word per lane, lane l at bits [64l+63:64l] |
| tx_valid | output | 2 | Beat valid per lane |
| tx_end_of_frame | output | 2 | Last beat of frame per lane |
| tx_dest_ip | output | 64 | Destination IP per lane, lane l at bits [32l+31:32l] |
| tx_dest_port | output | 16 | UDP destination port |

## Verification
A wrong position count shows up at the ports in two ways: end-of-frame lands on the wrong beat, or a lane receives data meant for its partner. Either appears within the packet in which the count goes wrong. A slipped destination index shows up on the next header beat as the wrong table entry, and a failed wrap shows up on the 17th packet. A hold register that drops or repeats a word shows as a shifted payload on the very next beat.

// File: rtl/udp_group_framer.sv
module udp_group_framer #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 32,
  parameter int IP_W   = 32,
  parameter int PORT_W = 16,
  parameter int BEATS  = 256,
  parameter int DESTS  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_W-1:0]     in_data,
  input  logic                  in_valid,
  input  logic [CNT_W-1:0]      spec_count,
  input  logic [DESTS*IP_W-1:0] dest_table,
  input  logic [PORT_W-1:0]     udp_port,
  output logic [2*DATA_W-1:0]   tx_data,
  output logic [1:0]            tx_valid,
  output logic [1:0]            tx_end_of_frame,
  output logic [2*IP_W-1:0]     tx_dest_ip,
  output logic [PORT_W-1:0]     tx_dest_port
);
  localparam int WC_W  = $clog2(BEATS);
  localparam int DI_W  = (DESTS > 1) ? $clog2(DESTS) : 1;
  localparam int LANES = 2;

  logic [WC_W:0]   pos;
  logic [DI_W-1:0] dest_idx;

  wire             lane_sel  = pos[WC_W];
  wire [WC_W-1:0]  wcnt      = pos[WC_W-1:0];
  wire             pkt_first = (wcnt == '0);
  wire             pkt_last  = (wcnt == WC_W'(BEATS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      dest_idx <= '0;
    end else if (in_valid) begin
      pos <= pos + 1'b1;
      if (pkt_last)
        dest_idx <= (dest_idx == DI_W'(DESTS-1)) ? '0 : dest_idx + 1'b1;
    end
  end

  assign tx_dest_port = udp_port;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wire acc   = in_valid && (lane_sel == 1'(l));
    wire start = acc && pkt_first;

    logic [DATA_W-1:0] held_q, out_q;
    logic              held_v, held_last, out_v, out_eof;
    logic [IP_W-1:0]   ip_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held_q    <= '0;
        held_v    <= 1'b0;
        held_last <= 1'b0;
        out_q     <= '0;
        out_v     <= 1'b0;
        out_eof   <= 1'b0;
        ip_q      <= '0;
      end else begin
        if (start) begin
          out_q   <= DATA_W'(spec_count);
          out_v   <= 1'b1;
          out_eof <= 1'b0;
          ip_q    <= dest_table[dest_idx*IP_W +: IP_W];
        end else begin
          out_q   <= held_q;
          out_v   <= held_v;
          out_eof <= held_v && held_last;
        end
        held_v    <= acc;
        held_last <= acc && pkt_last;
        if (acc) held_q <= in_data;
      end
    end

    assign tx_data[l*DATA_W +: DATA_W] = out_q;
    assign tx_valid[l]                 = out_v;
    assign tx_end_of_frame[l]          = out_eof;
    assign tx_dest_ip[l*IP_W +: IP_W]  = ip_q;

    logic [WC_W:0] nbeat;
    always_ff @(posedge clk) begin
      if (!rst_n)                nbeat <= '0;
      else if (tx_valid[l])      nbeat <= tx_end_of_frame[l] ? '0 : nbeat + 1'b1;
    end

    assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid[l] && tx_end_of_frame[l]) |-> (nbeat == (WC_W+1)'(BEATS)));

    assert_eof_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_end_of_frame[l] |-> tx_valid[l]);

    assert_eof_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_end_of_frame[l] |=> !tx_end_of_frame[l]);

    assert_ip_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid[l] && !tx_end_of_frame[l]) |=> $stable(tx_dest_ip[l*IP_W +: IP_W]));
  end

endmodule

// File: tb/udp_group_framer_bench.sv
`timescale 1ns/1ps
module udp_group_framer_bench;
  localparam int NPKT = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [63:0]   in_data = '0;
  logic          in_valid = 1'b0;
  logic [31:0]   spec_count = '0;
  logic [511:0]  dest_table;
  logic [15:0]   udp_port = 16'd50000;
  logic [127:0]  tx_data;
  logic [1:0]    tx_valid, tx_end_of_frame;
  logic [63:0]   tx_dest_ip;
  logic [15:0]   tx_dest_port;

  always #2.5 clk = ~clk;

  udp_group_framer u_udp_group_framer (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .spec_count(spec_count), .dest_table(dest_table), .udp_port(udp_port),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_end_of_frame(tx_end_of_frame),
    .tx_dest_ip(tx_dest_ip), .tx_dest_port(tx_dest_port));

  // entry: {pkt[7:0], is_hdr, eof, ip[31:0], data[63:0]}
  typedef logic [105:0] ent_t;
  ent_t q0[$];
  ent_t q1[$];

  int nchk = 0, nfail = 0;
  bit monitor_on = 0;
  int b_w = 0, b_pkt = 0, b_idx = 0;

  function automatic logic [31:0] exp_ip(input int idx);
    return dest_table[idx*32 +: 32];
  endfunction

  function automatic logic [63:0] exp_header(input logic [31:0] c);
    return {32'd0, c};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input int lane, input ent_t e);
    if (lane == 0) q0.push_back(e); else q1.push_back(e);
  endtask

  task automatic drive(input bit v);
    @(negedge clk);
    in_valid   = v;
    in_data    = {$urandom, $urandom};
    spec_count = $urandom;
    if (v) begin
      if (b_w == 0)
        push(b_pkt % 2, {8'(b_pkt), 1'b1, 1'b0, exp_ip(b_idx), exp_header(spec_count)});
      push(b_pkt % 2, {8'(b_pkt), 1'b0, (b_w == 255), exp_ip(b_idx), in_data});
      b_w++;
      if (b_w == 256) begin
        b_w = 0;
        b_pkt++;
        b_idx = (b_idx + 1) % 16;
      end
    end
  endtask

  always @(negedge clk) begin
    if (monitor_on) begin
      for (int l = 0; l < 2; l++) begin
        if (tx_valid[l]) begin
          if ((l == 0 ? q0.size() : q1.size()) == 0) begin
            check(1'b0, $sformatf("R6 lane %0d unexpected beat", l), 64'(tx_valid), 64'd0);
          end else begin
            ent_t e;
            e = (l == 0) ? q0.pop_front() : q1.pop_front();
            check(tx_data[l*64 +: 64] == e[63:0],
                  e[97] ? $sformatf("R2 lane %0d header", l) : $sformatf("R3 lane %0d data", l),
                  tx_data[l*64 +: 64], e[63:0]);
            check(tx_end_of_frame[l] == e[96], $sformatf("R5 lane %0d eof", l),
                  64'(tx_end_of_frame[l]), 64'(e[96]));
            check(tx_dest_ip[l*32 +: 32] == e[95:64],
                  (e[105:98] >= 8'd16) ? $sformatf("R8 lane %0d ip after wrap", l)
                                       : $sformatf("R7 lane %0d ip", l),
                  64'(tx_dest_ip[l*32 +: 32]), 64'(e[95:64]));
          end
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7151));
    for (int i = 0; i < 16; i++) dest_table[i*32 +: 32] = {8'd10, 8'd0, 8'(i), 8'($urandom)};
    repeat (4) @(negedge clk);
    check(tx_valid == 2'b00, "R1 valid after reset", 64'(tx_valid), 64'd0);
    check(tx_end_of_frame == 2'b00, "R1 eof after reset", 64'(tx_end_of_frame), 64'd0);
    #1 check(tx_dest_port == udp_port, "R10 port", 64'(tx_dest_port), 64'(udp_port));
    @(negedge clk);
    rst_n = 1'b1;
    monitor_on = 1;
    for (int p = 0; p < NPKT; p++) begin
      for (int w = 0; w < 256; w++) begin
        if (p == 2 && w == 128) begin
          for (int s = 0; s < 4; s++) begin
            drive(1'b0);
            if (s >= 2) begin
              #1;
              check(tx_valid[0] == 1'b0, "R9 valid low in stall", 64'(tx_valid[0]), 64'd0);
              check(tx_end_of_frame == 2'b00, "R9 no early eof", 64'(tx_end_of_frame), 64'd0);
            end
          end
        end
        if (p >= 3) while ($urandom_range(3) == 0) drive(1'b0);
        if (p == 9 && w == 40) begin
          udp_port = 16'($urandom);
          #1 check(tx_dest_port == udp_port, "R10 port follows", 64'(tx_dest_port), 64'(udp_port));
        end
        drive(1'b1);
      end
    end
    repeat (6) drive(1'b0);
    check(q0.size() == 0, "R4 lane 0 beats outstanding", 64'(q0.size()), 64'd0);
    check(q1.size() == 0, "R4 lane 1 beats outstanding", 64'(q1.size()), 64'd0);
    check(tx_valid == 2'b00, "R9 idle after last frame", 64'(tx_valid), 64'd0);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule